// File: doc/BRIEF.md
# Frame Extrema Unit

This block scans one frame of eight signed samples that sit in an external single-port memory and reports the smallest and the largest of them. It reads the memory through a read-only port: an address, a chip-enable and a read-data input, with no write path at all. Once started it issues the eight addresses in order, one per cycle. It compares each returned sample in the cycle after its read and keeps a running minimum and maximum.

A block-level handshake governs the unit. `start` launches a frame whenever `ready` is high. `idle` and `ready` drop while the frame is in flight. `done` pulses together with the two result strobes `min_valid` and `max_valid` when the last comparison lands. If `start` is still high on that completion cycle, the next frame begins at once. The reset input is synchronous, and a parameter chooses whether it is active-high or active-low.

Top module: `frame_extrema`

## Requirements
- R1: While reset is active and in the cycle after it, `idle` and `ready` are 1, and `done`, `min_valid`, `max_valid` and `mem_ce` are 0. A reset applied in the middle of a frame abandons that frame.
- R2: With `RST_ACTIVE_HIGH`=1 the reset is asserted by `rst_in`=1. With `RST_ACTIVE_HIGH`=0 it is asserted by `rst_in`=0.
- R3: `start` is accepted only at a clock edge where `ready` is 1. A `start` pulse while a frame is running is ignored and is not remembered afterwards. `mem_ce` is never 1 while `idle` is 1.
- R4: After the accepting edge, `mem_ce` is 1 for exactly 8 consecutive cycles, and `mem_addr` runs 0,1,…,7 in those cycles.
- R5: Read data has a latency of one cycle. The sample for an address is taken from `mem_rdata` in the cycle after the one in which that address is presented with `mem_ce`=1. Values on `mem_rdata` in other cycles have no effect.
- R6: `min_out` is the smallest and `max_out` the largest of the eight samples, read as two's-complement signed values of width `DATA_W`.
- R7: `done`, `min_valid` and `max_valid` are 1 together for exactly one cycle, which begins at the ninth rising edge after the accepting edge.
- R8: `idle` rises in the same cycle as `done` and stays high until the next accepted start. `ready` equals `idle`.
- R9: If `start` is 1 during the `done` cycle, the next edge begins a new frame: `idle` is 0 and `mem_ce` is 1 with `mem_addr`=0 in the following cycle.
- R10: `min_out` and `max_out` keep their values after the strobes fall, until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Synchronous reset, polarity set by `RST_ACTIVE_HIGH` |
| start | input | 1 | Request to scan one frame |
| ready | output | 1 | A start can be accepted at the next edge |
| done | output | 1 | One-cycle completion pulse |
| idle | output | 1 | No frame in progress |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ce | output | 1 | Memory chip-enable (read request) |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the request |
| min_out | output | DATA_W | Smallest signed sample of the last frame |
| min_valid | output | 1 | `min_out` is fresh this cycle |
| max_out | output | DATA_W | Largest signed sample of the last frame |
| max_valid | output | 1 | `max_out` is fresh this cycle |

## Verification
The hardest case to reach is the completion cycle that doubles as a start. In that single cycle the last sample is compared, `done` is high and a new request is accepted, and the memory contents must change between the two frames. The stimulus keeps `start` high through the first frame. It rewrites the bench memory on the `done` cycle, before the second frame's first read. It then checks the restart cycle and the new results. To test the one-cycle latency, the bench memory puts a poison value on its read data in every cycle without a request, so any sample taken from the wrong cycle shows up in the results.

// File: rtl/fx_pkg.sv
package fx_pkg;

  typedef enum logic [0:0] {
    FX_IDLE = 1'b0,
    FX_BUSY = 1'b1
  } fx_state_e;

  function automatic int fx_addr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/fx_rst_norm.sv
module fx_rst_norm #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic rst_in,
  output logic rst
);

  generate
    if (ACTIVE_HIGH) begin : g_high
      assign rst = rst_in;
    end else begin : g_low
      assign rst = ~rst_in;
    end
  endgenerate

endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic final_cmp,
  output logic go,
  output logic ready,
  output logic idle,
  output logic done
);

  fx_state_e state_q;
  logic      done_q;

  assign idle  = (state_q == FX_IDLE);
  assign ready = idle;
  assign go    = start && idle;
  assign done  = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FX_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= final_cmp;
      unique case (state_q)
        FX_IDLE: if (go)        state_q <= FX_BUSY;
        FX_BUSY: if (final_cmp) state_q <= FX_IDLE;
        default:                state_q <= FX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fx_addr_gen.sv
module fx_addr_gen #(
  parameter int FRAME_LEN = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce,
  output logic              smp_vld,
  output logic              smp_first,
  output logic              smp_last
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_LEN - 1);

  logic [ADDR_W-1:0] cnt_q;
  logic              ce_q;

  assign mem_addr = cnt_q;
  assign mem_ce   = ce_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ce_q  <= 1'b0;
    end else if (go) begin
      cnt_q <= '0;
      ce_q  <= 1'b1;
    end else if (ce_q) begin
      if (cnt_q == LAST_ADDR) begin
        ce_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Tags travel alongside the one-cycle memory latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_vld   <= 1'b0;
      smp_first <= 1'b0;
      smp_last  <= 1'b0;
    end else begin
      smp_vld   <= ce_q;
      smp_first <= ce_q && (cnt_q == '0);
      smp_last  <= ce_q && (cnt_q == LAST_ADDR);
    end
  end

endmodule

// File: rtl/fx_minmax.sv
module fx_minmax #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_vld,
  input  logic              smp_first,
  input  logic              smp_last,
  input  logic [DATA_W-1:0] rdata,
  output logic              final_cmp,
  output logic [DATA_W-1:0] min_out,
  output logic              min_valid,
  output logic [DATA_W-1:0] max_out,
  output logic              max_valid
);

  logic signed [DATA_W-1:0] smp;
  logic signed [DATA_W-1:0] run_min_q, run_max_q;
  logic signed [DATA_W-1:0] nxt_min, nxt_max;
  logic signed [DATA_W-1:0] res_min_q, res_max_q;
  logic                     min_vld_q, max_vld_q;

  assign smp       = $signed(rdata);
  assign final_cmp = smp_vld && smp_last;

  // Strict comparisons: an equal sample leaves the held value in place.
  always_comb begin
    if (smp_first) begin
      nxt_min = smp;
      nxt_max = smp;
    end else begin
      nxt_min = (smp < run_min_q) ? smp : run_min_q;
      nxt_max = (smp > run_max_q) ? smp : run_max_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_min_q <= '0;
      run_max_q <= '0;
    end else if (smp_vld) begin
      run_min_q <= nxt_min;
      run_max_q <= nxt_max;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_min_q <= '0;
      res_max_q <= '0;
      min_vld_q <= 1'b0;
      max_vld_q <= 1'b0;
    end else begin
      min_vld_q <= final_cmp;
      max_vld_q <= final_cmp;
      if (final_cmp) begin
        res_min_q <= nxt_min;
        res_max_q <= nxt_max;
      end
    end
  end

  assign min_out   = res_min_q;
  assign max_out   = res_max_q;
  assign min_valid = min_vld_q;
  assign max_valid = max_vld_q;

endmodule

// File: rtl/frame_extrema.sv
module frame_extrema #(
  parameter int       FRAME_LEN       = 8,
  parameter int       DATA_W          = 16,
  parameter bit       RST_ACTIVE_HIGH = 1'b1,
  localparam int      ADDR_W          = fx_pkg::fx_addr_width(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_in,
  input  logic              start,
  output logic              ready,
  output logic              done,
  output logic              idle,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] min_out,
  output logic              min_valid,
  output logic [DATA_W-1:0] max_out,
  output logic              max_valid
);

  logic rst_hi;
  logic go;
  logic smp_vld, smp_first, smp_last;
  logic final_cmp;

  fx_rst_norm #(.ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_rst (
    .rst_in (rst_in),
    .rst    (rst_hi)
  );

  fx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst_hi),
    .start     (start),
    .final_cmp (final_cmp),
    .go        (go),
    .ready     (ready),
    .idle      (idle),
    .done      (done)
  );

  fx_addr_gen #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst_hi),
    .go        (go),
    .mem_addr  (mem_addr),
    .mem_ce    (mem_ce),
    .smp_vld   (smp_vld),
    .smp_first (smp_first),
    .smp_last  (smp_last)
  );

  fx_minmax #(.DATA_W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst       (rst_hi),
    .smp_vld   (smp_vld),
    .smp_first (smp_first),
    .smp_last  (smp_last),
    .rdata     (mem_rdata),
    .final_cmp (final_cmp),
    .min_out   (min_out),
    .min_valid (min_valid),
    .max_out   (max_out),
    .max_valid (max_valid)
  );

endmodule

// File: rtl/fx_checker.sv
module fx_checker #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int FRAME_LEN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              ready,
  input logic              idle,
  input logic              done,
  input logic              mem_ce,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] min_out,
  input logic [DATA_W-1:0] max_out,
  input logic              min_valid,
  input logic              max_valid
);

  a_r3_no_read_when_idle: assert property (@(posedge clk) disable iff (rst)
    mem_ce |-> !idle);

  a_r4_addr_in_frame: assert property (@(posedge clk) disable iff (rst)
    mem_ce |-> (int'(mem_addr) < FRAME_LEN));

  a_r4_addr_sequential: assert property (@(posedge clk) disable iff (rst)
    (mem_ce && $past(mem_ce)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_strobes_with_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (min_valid && max_valid));

  a_r6_min_not_above_max: assert property (@(posedge clk) disable iff (rst)
    min_valid |-> ($signed(min_out) <= $signed(max_out)));

  a_r8_idle_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (idle && ready));

  a_r9_start_launches: assert property (@(posedge clk) disable iff (rst)
    (idle && start) |=> (!idle && mem_ce && (mem_addr == '0)));

endmodule

bind frame_extrema fx_checker #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .FRAME_LEN (FRAME_LEN)
) u_fx_checker (
  .clk       (clk),
  .rst       (rst_hi),
  .start     (start),
  .ready     (ready),
  .idle      (idle),
  .done      (done),
  .mem_ce    (mem_ce),
  .mem_addr  (mem_addr),
  .min_out   (min_out),
  .max_out   (max_out),
  .min_valid (min_valid),
  .max_valid (max_valid)
);

// File: tb/test_frame_extrema.sv
module test_frame_extrema;

  localparam int DW = 16;
  localparam int AW = 3;
  localparam int NF = 6;
  localparam logic [DW-1:0] POISON = 16'h5A5A;

  // Stimulus frames and their expected signed extremes.
  localparam int FR [NF][8] = '{
    '{1, 2, 3, 4, 5, 6, 7, 8},
    '{8, 7, 6, 5, 4, 3, 2, 1},
    '{-5, 10, 0, -32768, 32767, 3, 3, -1},
    '{42, 42, 42, 42, 42, 42, 42, 42},
    '{-1, -2, -3, -4, -5, -6, -7, -8},
    '{100, -100, 50, 0, 7, -100, 100, 9}
  };
  localparam int EXP_MIN [NF] = '{1, 1, -32768, 42, -8, -100};
  localparam int EXP_MAX [NF] = '{8, 8, 32767, 42, -1, 100};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, rst_n, start, start_b;
  logic          ready, done, idle, mem_ce, min_valid, max_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, min_out, max_out;
  logic          ready_b, done_b, idle_b, ce_b, minv_b, maxv_b;
  logic [AW-1:0] addr_b;
  logic [DW-1:0] rdata_b, min_b, max_b;

  logic [DW-1:0] mem [8];

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  frame_extrema #(.RST_ACTIVE_HIGH(1'b1)) i_frame_extrema (
    .clk(clk), .rst_in(rst), .start(start), .ready(ready), .done(done),
    .idle(idle), .mem_addr(mem_addr), .mem_ce(mem_ce), .mem_rdata(mem_rdata),
    .min_out(min_out), .min_valid(min_valid), .max_out(max_out),
    .max_valid(max_valid)
  );

  frame_extrema #(.RST_ACTIVE_HIGH(1'b0)) i_frame_extrema_low (
    .clk(clk), .rst_in(rst_n), .start(start_b), .ready(ready_b), .done(done_b),
    .idle(idle_b), .mem_addr(addr_b), .mem_ce(ce_b), .mem_rdata(rdata_b),
    .min_out(min_b), .min_valid(minv_b), .max_out(max_b), .max_valid(maxv_b)
  );

  // Synchronous memories; poison on cycles without a request (R5).
  always @(posedge clk) begin
    mem_rdata <= mem_ce ? mem[mem_addr] : POISON;
    rdata_b   <= ce_b ? mem[addr_b] : POISON;
  end

  // Address-order monitor for R4.
  int seq_idx = 0, run_len = 0, last_len = 0, seq_bad = 0;
  always @(posedge clk) begin
    if (mem_ce) begin
      if (int'(mem_addr) != seq_idx) seq_bad <= seq_bad + 1;
      seq_idx <= seq_idx + 1;
      run_len <= run_len + 1;
    end else begin
      seq_idx <= 0;
      if (run_len != 0) last_len <= run_len;
      run_len <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int f);
    for (int i = 0; i < 8; i++) mem[i] = DW'(FR[f][i]);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic check_results(input int f, input string req);
    chk(done && min_valid && max_valid, "R7", "strobes on ninth edge",
        {done, min_valid, max_valid}, 3'b111);
    chk($signed(min_out) == EXP_MIN[f], req, "minimum",
        $signed(min_out), EXP_MIN[f]);
    chk($signed(max_out) == EXP_MAX[f], req, "maximum",
        $signed(max_out), EXP_MAX[f]);
    chk(idle && ready, "R8", "idle and ready with done", {idle, ready}, 2'b11);
  endtask

  task automatic run_frame(input int f);
    load(f);
    pulse_start();
    chk(!idle && mem_ce && mem_addr == 0, "R4", "first read after accept",
        {idle, mem_ce, mem_addr}, 5'b01000);
    repeat (8) @(negedge clk);
    chk(!done, "R7", "done not early", done, 0);
    @(negedge clk);
    check_results(f, "R6");
    chk(last_len == 8 && seq_bad == 0, "R4", "eight sequential reads",
        last_len, 8);
    @(negedge clk);
    chk(!done && !min_valid && !max_valid, "R7", "strobes one cycle",
        {done, min_valid, max_valid}, 0);
    chk($signed(min_out) == EXP_MIN[f] && $signed(max_out) == EXP_MAX[f],
        "R10", "results held", $signed(min_out), EXP_MIN[f]);
    chk(idle, "R8", "idle stays", idle, 1);
  endtask

  initial begin
    start = 1'b0; start_b = 1'b0; rst = 1'b1; rst_n = 1'b0;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(idle && ready && !done && !min_valid && !max_valid && !mem_ce, "R1",
        "state in reset", {idle, ready, done, min_valid, max_valid, mem_ce},
        6'b110000);
    chk(idle_b && !ce_b && !done_b, "R2", "active-low reset holds",
        {idle_b, ce_b, done_b}, 3'b100);
    rst = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk(idle && ready && !mem_ce && !done, "R1", "state after reset",
        {idle, ready, mem_ce, done}, 4'b1100);

    // Table walk.
    for (int f = 0; f < NF; f++) run_frame(f);

    // R3: start during a running frame is ignored.
    load(2);
    pulse_start();
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!done, "R3", "busy start does not disturb timing", done, 0);
    @(negedge clk);
    check_results(2, "R3");
    @(negedge clk);
    chk(idle && !mem_ce, "R3", "busy start not remembered",
        {idle, mem_ce}, 2'b10);

    // R9: start held through done starts the next frame at once.
    load(0);
    @(negedge clk); start = 1'b1;
    repeat (9) @(negedge clk);
    @(negedge clk);
    check_results(0, "R9");
    load(4);
    @(negedge clk);
    chk(!idle && mem_ce && mem_addr == 0, "R9", "back-to-back launch",
        {idle, mem_ce, mem_addr}, 5'b01000);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk(!done, "R9", "second frame not early", done, 0);
    @(negedge clk);
    check_results(4, "R9");
    @(negedge clk);

    // R1: reset in the middle of a frame.
    load(3);
    pulse_start();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(idle && ready && !mem_ce && !done && !min_valid && !max_valid, "R1",
        "mid-frame reset", {idle, ready, mem_ce, done, min_valid, max_valid},
        6'b110000);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk(!done && idle, "R1", "aborted frame never completes", done, 0);
    run_frame(3);

    // R2: active-low instance runs and resets on a low level.
    load(5);
    @(negedge clk); start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    repeat (8) @(negedge clk);
    @(negedge clk);
    chk(done_b && $signed(min_b) == -100 && $signed(max_b) == 100, "R2",
        "active-low instance frame", $signed(min_b), -100);
    @(negedge clk); start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    repeat (2) @(negedge clk);
    chk(ce_b && !idle_b, "R2", "running before low reset", {ce_b, idle_b}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    chk(idle_b && !ce_b, "R2", "low level resets", {idle_b, ce_b}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);

    ended = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!ended) begin
      checks++; fails++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule